// File: doc/BRIEF.md
# Threshold-Compare Pulse-Per-Second Generator

This block produces a once-per-second pulse from a free-running nanosecond count supplied by a neighbouring time counter. A compare threshold holds the nanosecond value at which the next output edge is due. When the live count reaches that threshold, the output toggles. The threshold then moves forward by one of two increments: the high-phase increment after a rising transition and the low-phase increment after a falling one. The ratio between the two increments sets the duty cycle. Both increments and the threshold use a 32.32 fixed-point format, with whole nanoseconds in the upper 32 bits and a fraction in the lower 32 bits, so fractional nanoseconds build up from edge to edge.

The threshold wraps modulo the rollover period (10^9 ns by default) in step with the nanosecond counter. A threshold that wraps is not compared until the counter has rolled over. The host reaches the block through a simple write port that selects one of four registers. These are a control word carrying an enable bit and a polarity-invert bit, the two increments, and the threshold itself. A typical setup uses half a second for each increment, which gives a 1 Hz square wave at 50% duty.

Top module: `pps_thresh_gen`

## Requirements
- R1: After reset the output is 0 and the block is disabled. Both increments reset to half the rollover period in whole nanoseconds with zero fraction, and the threshold resets to the same value.
- R2: A write with select 0 loads the control word: bit 30 is enable and bit 31 is invert. Select 1 loads the high-phase increment, select 2 the low-phase increment, and select 3 the threshold. All three are 64-bit 32.32 values with nanoseconds in bits 63:32.
- R3: While enabled and not waiting for a rollover, a sampled count greater than or equal to the threshold's whole-nanosecond part toggles the internal phase at that clock edge. The output therefore changes one cycle after the count is presented, and without such a hit the phase holds.
- R4: The edge that makes the phase high advances the threshold by the high-phase increment. The edge that makes it low advances it by the low-phase increment.
- R5: The advanced threshold is reduced modulo the rollover period. When it wraps, no comparison takes place until the count is seen to fall below its previous value, which marks a rollover. The comparison resumes in that same cycle.
- R6: Because the comparison is greater-or-equal, a count that steps past the exact threshold value still produces the edge.
- R7: While disabled, the phase is forced low at each clock edge, the threshold does not advance, and the output sits at its inactive level, which equals the invert bit.
- R8: The output equals the phase exclusive-ORed with the invert bit.
- R9: A threshold write replaces the threshold and cancels any pending rollover wait. If it coincides with a hit, the written value wins over the advance, and the phase still toggles.
- R10: The fractional parts of the threshold and increment add with a carry into the nanosecond part. Over many edges, whole-nanosecond edge times therefore follow the exact fractional sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ns_count_i | input | NS_W | Live nanosecond count, wrapping at ROLL_NS |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 high increment, 2 low increment, 3 threshold |
| wr_data_i | input | 64 | Write data |
| pps_o | output | 1 | Pulse-per-second output |

## Verification
Each count value is sampled at one rising edge, and an edge caused by that value shows on `pps_o` just after the edge. Register writes take effect at the edge that captures them. The enable bit therefore governs comparisons from the following edge on. The bench presents each count at a falling edge. It updates an unwrapped, absolute-time model of the expected phase for the coming edge, and compares `pps_o` at the next falling edge. The model places edges with 64-bit arithmetic on absolute time, not on the wrapped count, so rollover handling in the design is checked against an independent formulation.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int unsigned TS_INT_W  = 32;
  localparam int unsigned TS_FRAC_W = 32;
  localparam int unsigned TS_W      = TS_INT_W + TS_FRAC_W;

  // Control word bit positions
  localparam int unsigned CTRL_EN_BIT  = 30;
  localparam int unsigned CTRL_INV_BIT = 31;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_THR  = 2'd3
  } pps_sel_e;

  typedef logic [TS_W-1:0]     ts_t;
  typedef logic [TS_INT_W-1:0] ns_t;

  // Whole-ns part of thr+inc before modulo reduction
  function automatic logic [TS_INT_W:0] pps_sum_whole(ts_t thr, ts_t inc);
    logic [TS_W:0] sum;
    sum = {1'b0, thr} + {1'b0, inc};
    return sum[TS_W:TS_FRAC_W];
  endfunction

  // True when thr+inc crosses the rollover period
  function automatic logic pps_adv_wraps(ts_t thr, ts_t inc, ns_t roll);
    return pps_sum_whole(thr, inc) >= {1'b0, roll};
  endfunction

  // Next threshold: thr+inc, whole part reduced modulo roll
  function automatic ts_t pps_advance(ts_t thr, ts_t inc, ns_t roll);
    logic [TS_W:0]     sum;
    logic [TS_INT_W:0] whole;
    sum   = {1'b0, thr} + {1'b0, inc};
    whole = sum[TS_W:TS_FRAC_W];
    if (whole >= {1'b0, roll}) begin
      whole = whole - {1'b0, roll};
    end
    return {whole[TS_INT_W-1:0], sum[TS_FRAC_W-1:0]};
  endfunction

endpackage

// File: rtl/pps_cfg_regs.sv
module pps_cfg_regs
  import pps_pkg::*;
#(
  parameter int unsigned ROLL_NS = 1000000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  ts_t        wr_data,
  output logic       en,
  output logic       inv,
  output ts_t        hi_inc,
  output ts_t        lo_inc,
  output logic       thr_wr,
  output ts_t        thr_wr_val
);

  localparam ts_t HALF_SEC = {TS_INT_W'(ROLL_NS / 2), TS_FRAC_W'(0)};

  pps_sel_e sel;
  assign sel = pps_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      inv    <= 1'b0;
      hi_inc <= HALF_SEC;
      lo_inc <= HALF_SEC;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          en  <= wr_data[CTRL_EN_BIT];
          inv <= wr_data[CTRL_INV_BIT];
        end
        SEL_HI:  hi_inc <= wr_data;
        SEL_LO:  lo_inc <= wr_data;
        default: ;
      endcase
    end
  end

  // Threshold lives in the compare unit; hand the write over
  assign thr_wr     = wr_en && (sel == SEL_THR);
  assign thr_wr_val = wr_data;

endmodule

// File: rtl/pps_thresh_unit.sv
module pps_thresh_unit
  import pps_pkg::*;
#(
  parameter int unsigned NS_W    = 30,
  parameter int unsigned ROLL_NS = 1000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NS_W-1:0] ns_count,
  input  ts_t             inc,
  input  logic            thr_wr,
  input  ts_t             thr_wr_val,
  output logic            hit,
  output logic            roll_seen,
  output logic            adv_wraps,
  output logic            wait_wrap,
  output ts_t             thr_q
);

  localparam ns_t ROLL     = ns_t'(ROLL_NS);
  localparam ts_t HALF_SEC = {TS_INT_W'(ROLL_NS / 2), TS_FRAC_W'(0)};

  logic [NS_W-1:0] prev_cnt;
  ns_t             cnt_ext;
  logic            wait_eff;
  ts_t             thr_next;

  assign cnt_ext   = ns_t'(ns_count);
  assign roll_seen = ns_count < prev_cnt;
  assign wait_eff  = wait_wrap && !roll_seen;
  assign hit       = en && !wait_eff && (cnt_ext >= thr_q[TS_W-1:TS_FRAC_W]);
  assign thr_next  = pps_advance(thr_q, inc, ROLL);
  assign adv_wraps = pps_adv_wraps(thr_q, inc, ROLL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cnt  <= '0;
      thr_q     <= HALF_SEC;
      wait_wrap <= 1'b0;
    end else begin
      prev_cnt <= ns_count;
      if (thr_wr) begin
        thr_q     <= thr_wr_val;
        wait_wrap <= 1'b0;
      end else if (!en) begin
        wait_wrap <= 1'b0;
      end else if (hit) begin
        thr_q     <= thr_next;
        wait_wrap <= adv_wraps;
      end else if (roll_seen) begin
        wait_wrap <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pps_phase_out.sv
module pps_phase_out (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic inv,
  input  logic hit,
  output logic phase,
  output logic pps_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
    end else if (!en) begin
      phase <= 1'b0;
    end else if (hit) begin
      phase <= ~phase;
    end
  end

  assign pps_o = phase ^ inv;

endmodule

// File: rtl/pps_thresh_gen.sv
module pps_thresh_gen
  import pps_pkg::*;
#(
  parameter int unsigned NS_W    = 30,
  parameter int unsigned ROLL_NS = 1000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS_W-1:0] ns_count_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [63:0]     wr_data_i,
  output logic            pps_o
);

  logic en, inv, thr_wr, hit, roll_seen, adv_wraps, wait_wrap, phase;
  ts_t  hi_inc, lo_inc, thr_wr_val, thr_q, inc_sel;

  pps_cfg_regs #(.ROLL_NS(ROLL_NS)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_sel     (wr_sel_i),
    .wr_data    (wr_data_i),
    .en         (en),
    .inv        (inv),
    .hi_inc     (hi_inc),
    .lo_inc     (lo_inc),
    .thr_wr     (thr_wr),
    .thr_wr_val (thr_wr_val)
  );

  // Low phase now means the coming edge rises: use the high increment
  assign inc_sel = phase ? lo_inc : hi_inc;

  pps_thresh_unit #(.NS_W(NS_W), .ROLL_NS(ROLL_NS)) thr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ns_count   (ns_count_i),
    .inc        (inc_sel),
    .thr_wr     (thr_wr),
    .thr_wr_val (thr_wr_val),
    .hit        (hit),
    .roll_seen  (roll_seen),
    .adv_wraps  (adv_wraps),
    .wait_wrap  (wait_wrap),
    .thr_q      (thr_q)
  );

  pps_phase_out out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .inv   (inv),
    .hit   (hit),
    .phase (phase),
    .pps_o (pps_o)
  );

endmodule

// File: rtl/pps_thresh_gen_chk.sv
module pps_thresh_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic hit,
  input logic phase,
  input logic thr_wr,
  input logic adv_wraps,
  input logic wait_wrap,
  input logic roll_seen
);

  assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !phase);

  assert_hold_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> (phase == $past(phase)));

  assert_toggle_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |=> (phase != $past(phase)));

  assert_wrap_defers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && !thr_wr && adv_wraps) |=> wait_wrap);

  assert_no_hit_waiting_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_wrap && !roll_seen) |-> !hit);

  assert_write_clears_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !wait_wrap);

endmodule

bind pps_thresh_gen pps_thresh_gen_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .hit       (hit),
  .phase     (phase),
  .thr_wr    (thr_wr),
  .adv_wraps (adv_wraps),
  .wait_wrap (wait_wrap),
  .roll_seen (roll_seen)
);

// File: tb/pps_thresh_gen_tb_top.sv
module pps_thresh_gen_tb_top;

  localparam int unsigned NS_W = 30;
  localparam int unsigned ROLL = 1000;
  localparam longint unsigned ROLL_SH = longint'(ROLL) << 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS_W-1:0] ns_count = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_sel = '0;
  logic [63:0]     wr_data = '0;
  logic            pps_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Absolute-time reference model
  longint unsigned t_abs = 0;
  longint unsigned abs_thr = 0;
  longint unsigned thr_w = longint'(ROLL / 2) << 32;
  longint unsigned hi = longint'(ROLL / 2) << 32;
  longint unsigned lo = longint'(ROLL / 2) << 32;
  int unsigned     step = 1;
  bit m_en = 0, m_inv = 0, m_phase = 0, arm_pending = 0;

  pps_thresh_gen #(.NS_W(NS_W), .ROLL_NS(ROLL)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ns_count_i (ns_count),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .pps_o      (pps_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pps_o=%0b expected %0b (t=%0d)", tag, got, exp, t_abs);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One clock: check previous edge, present new count, model next edge
  task automatic cycle(input bit do_wr, input logic [1:0] sel,
                       input logic [63:0] data, input string tag);
    bit new_en;
    @(negedge clk);
    check(pps_o, m_phase ^ m_inv, tag);
    t_abs += step;
    ns_count = NS_W'(t_abs % ROLL);
    wr_en = do_wr; wr_sel = sel; wr_data = data;
    if (m_en) begin
      if (arm_pending) begin
        abs_thr = (((t_abs / ROLL) * ROLL) << 32) + thr_w;
        arm_pending = 0;
      end
      if (t_abs >= (abs_thr >> 32)) begin
        abs_thr += m_phase ? lo : hi;   // R4 increment choice
        m_phase = ~m_phase;
      end
    end else begin
      m_phase = 0;                      // R7
    end
    if (do_wr) begin
      case (sel)
        2'd0: begin                     // R2 control: bit 30 enable, bit 31 invert
          new_en = data[30];
          if (m_en && !new_en) thr_w = abs_thr % ROLL_SH;
          if (!m_en && new_en) arm_pending = 1;
          m_en = new_en;
          m_inv = data[31];
        end
        2'd1: hi = data;
        2'd2: lo = data;
        default: begin                  // R9 threshold write
          if (m_en) begin
            abs_thr = (((t_abs / ROLL) * ROLL) << 32) + data;
            arm_pending = 0;
          end else begin
            thr_w = data;
          end
        end
      endcase
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 64'd0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] data, input string tag);
    cycle(1'b1, sel, data, tag);
  endtask

  localparam logic [63:0] CTRL_EN  = 64'h0000_0000_4000_0000;
  localparam logic [63:0] CTRL_INV = 64'h0000_0000_8000_0000;

  initial begin
    repeat (3) @(negedge clk);
    check(pps_o, 1'b0, "R1 reset output");
    rst_n = 1'b1;
    run(5, "R1 idle after reset");

    // R1 R3 R5: reset increments and threshold give 50% duty, wrap at 0
    wr(2'd0, CTRL_EN, "R1 enable");
    run(2600, "R1 R3 R5 default timing");

    // R2 R7: invert only, disabled -> output at inactive level 1
    wr(2'd0, CTRL_INV, "R2 R7 invert while off");
    run(60, "R2 R7 inactive level");

    // R4 R8: 300/700 split, inverted
    step = 3;
    wr(2'd1, 64'd300 << 32, "R4 hi write");
    wr(2'd2, 64'd700 << 32, "R4 lo write");
    wr(2'd3, 64'd500 << 32, "R4 thr write");
    wr(2'd0, CTRL_EN | CTRL_INV, "R8 enable inverted");
    run(2600, "R4 R8 unequal phases");

    // R7: disable mid-run, count keeps passing thresholds
    wr(2'd0, 64'd0, "R7 disable");
    run(700, "R7 held while disabled");

    // R6 R10: fractional increments 250.5 / 249.5, step 7 jumps past values
    step = 7;
    wr(2'd1, 64'h0000_00FA_8000_0000, "R10 hi frac");
    wr(2'd2, 64'h0000_00F9_8000_0000, "R10 lo frac");
    wr(2'd3, 64'd500 << 32, "R10 thr");
    wr(2'd0, CTRL_EN, "R6 enable");
    run(3000, "R6 R10 stepping fraction");

    // R9: live threshold writes while enabled
    step = 2;
    wr(2'd1, 64'd300 << 32, "R9 hi");
    wr(2'd2, 64'd700 << 32, "R9 lo");
    for (int k = 0; k < 8; k++) begin
      run(150, "R9 between writes");
      while (!((t_abs % ROLL) >= 100 && (t_abs % ROLL) <= 700))
        cycle(1'b0, 2'd0, 64'd0, "R9 wait window");
      wr(2'd3, ((k % 2) == 0) ? (64'd50 << 32) : (64'd900 << 32), "R9 live write");
      run(3, "R9 after write");
    end
    run(1200, "R9 settle");

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    summary();
  end

endmodule